// File: doc/BRIEF.md
# I/O Coprocessor Startup Sequencer

This block brings an I/O coprocessor from reset to a configured state. After reset it stays idle until a channel attention pulse arrives. On that first pulse it samples a select input to pick its role. As master it fetches a five-byte boot record from a fixed high address. The record holds a system bus kind byte and a segment:offset pointer to a configuration block. The sequencer then reads the configuration block for the I/O bus width, the arbitration mode and a pointer to a control block. Last, it reads the control block for the first channel's table pointer. The second channel's table sits a fixed eight bytes above the first.

Every pointer is a 16-bit segment and a 16-bit offset, stored low byte first. The two are combined into a 20-bit physical address: the segment is shifted left by four bits, the offset is added, and the result wraps modulo 2^20. A slave skips the boot record. It waits for a second attention pulse and then reads its configuration block at a base address fixed by a parameter.

Memory is reached through a one-byte read port. Only one read is outstanding at a time, and each read completes on a valid strobe. Once every field is loaded, the sequencer raises a done flag and holds all configuration outputs steady until the next reset.

Top module: `iop_boot_seq`

## Requirements
- R1: While reset is asserted, and until the first accepted attention pulse, `mem_req`, `init_done` and `is_master` are 0, and `ch1_tbl_addr`, `cfg_blk_addr` and `ctl_blk_addr` are 0.
- R2: If `attn` is high with `sel_in` high at the first usable edge, the block becomes master. In the next cycle it requests address 0xFFFF6, then 0xFFFF7 to 0xFFFFA in turn. Byte 0 of this record appears on `sys_bus_kind`.
- R3: If `sel_in` is low on the first accepted attention, the block becomes slave and issues no read until a further `attn`. That later pulse starts reads at `SLAVE_CFG_BASE`, whatever `sel_in` is then. `is_master` stays 0 and `sys_bus_kind` stays 0.
- R4: In the boot record, bytes 1 and 2 are an offset and bytes 3 and 4 are a segment, each low byte first. `cfg_blk_addr` equals (segment << 4) + offset, modulo 2^20.
- R5: The configuration block is read at its base +0, then +2, +3, +4 and +5; the byte at +1 is never read. In byte +0, bit 0 drives `io_bus16` and bit 1 drives `arb_mode1`. Bytes +2/+3 are the control block offset and +4/+5 its segment, each low byte first. They give `ctl_blk_addr` by the same rule as R4.
- R6: The control block is read at its base +0 to +3: an offset, then a segment, each low byte first. Together they give `ch1_tbl_addr`. `ch2_tbl_addr` equals `ch1_tbl_addr` + 8, modulo 2^20.
- R7: While `mem_req` is high and `mem_rvalid` is low, `mem_req` and `mem_addr` hold in the next cycle. A byte is taken only on an edge where both are high, and the next address follows in the next cycle.
- R8: `init_done` rises one cycle after the last control block byte is accepted. It stays high with `mem_req` low until reset. `attn` has no effect while a read sequence runs or after done.
- R9: After `rst_n` is released, the block needs two clock edges before it can act. An `attn` sampled on either of those edges is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attn | input | 1 | Channel attention pulse |
| sel_in | input | 1 | Role select, sampled on first attention: 1 master, 0 slave |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_rdata | input | 8 | Read data, taken with `mem_rvalid` |
| mem_rvalid | input | 1 | Read data valid; completes the current request |
| is_master | output | 1 | Role chosen on first attention |
| io_bus16 | output | 1 | I/O bus is 16 bits wide when 1 |
| arb_mode1 | output | 1 | Bus request/grant arbitration mode 1 when 1 |
| sys_bus_kind | output | 8 | System bus kind byte from the boot record |
| cfg_blk_addr | output | 20 | Configuration block address |
| ctl_blk_addr | output | 20 | Control block address |
| ch1_tbl_addr | output | 20 | Channel 1 table address |
| ch2_tbl_addr | output | 20 | Channel 2 table address |
| init_done | output | 1 | All configuration loaded |

## Verification
The first request appears one cycle after the edge that accepts attention. Each later address appears one cycle after the edge that accepts the previous byte. `init_done` follows one cycle after the final byte. Reset release adds two dead edges. The bench keeps a behavioural model of expected addresses and done state, advanced with the same edge bookkeeping. It compares the model against the ports at every falling edge, so a result that arrives a cycle early or late shows as a mismatch. Read latency is varied from zero to three cycles, and attention is pulsed at random during and after the sequence.

// File: rtl/iop_boot_pkg.sv
package iop_boot_pkg;
  localparam int ADDR_W    = 20;
  localparam int PTR_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 3;
  localparam int NPTR      = 3;   // cfg block, ctl block, channel table
  localparam int BOOT_LEN  = 5;
  localparam int SCB_LEN   = 5;
  localparam int CB_LEN    = 4;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SLV_WAIT = 3'd1,
    ST_BOOT     = 3'd2,
    ST_SCB      = 3'd3,
    ST_CB       = 3'd4,
    ST_DONE     = 3'd5
  } seq_st_e;

  function automatic logic [IDX_W-1:0] seq_len(seq_st_e s);
    case (s)
      ST_BOOT: seq_len = IDX_W'(BOOT_LEN);
      ST_SCB:  seq_len = IDX_W'(SCB_LEN);
      ST_CB:   seq_len = IDX_W'(CB_LEN);
      default: seq_len = IDX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/iop_rst_sync.sv
module iop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/iop_seg_adder.sv
module iop_seg_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  assign seg_ext = ADDR_W'({seg, {SHIFT{1'b0}}});
  assign off_ext = ADDR_W'(off);
  assign addr    = seg_ext + off_ext;   // wraps modulo 2^ADDR_W
endmodule

// File: rtl/iop_seq_fsm.sv
module iop_seq_fsm
  import iop_boot_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 20'hFFFF6
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              attn,
  input  logic              sel_in,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] ctl_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output seq_st_e           st,
  output logic [IDX_W-1:0]  idx,
  output logic              accept,
  output logic              master,
  output logic              role_set,
  output logic              init_done
);
  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             master_q, master_d;
  logic             role_q, role_d;
  logic             last_byte;
  logic [IDX_W-1:0] scb_off;

  assign mem_req   = (st_q == ST_BOOT) || (st_q == ST_SCB) || (st_q == ST_CB);
  assign accept    = mem_req && mem_rvalid;
  assign last_byte = (idx_q == seq_len(st_q) - IDX_W'(1));
  // configuration block skips the byte at +1
  assign scb_off   = (idx_q == '0) ? '0 : idx_q + IDX_W'(1);

  // next-state process
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    master_d = master_q;
    role_d   = role_q;
    case (st_q)
      ST_IDLE: begin
        if (attn) begin
          master_d = sel_in;
          role_d   = 1'b1;
          idx_d    = '0;
          st_d     = sel_in ? ST_BOOT : ST_SLV_WAIT;
        end
      end
      ST_SLV_WAIT: begin
        if (attn) begin
          idx_d = '0;
          st_d  = ST_SCB;
        end
      end
      ST_BOOT, ST_SCB, ST_CB: begin
        if (accept) begin
          if (last_byte) begin
            idx_d = '0;
            case (st_q)
              ST_BOOT: st_d = ST_SCB;
              ST_SCB:  st_d = ST_CB;
              default: st_d = ST_DONE;
            endcase
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: st_d = ST_DONE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      master_q <= 1'b0;
      role_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      master_q <= master_d;
      role_q   <= role_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_BOOT: mem_addr = BOOT_ADDR + ADDR_W'(idx_q);
      ST_SCB:  mem_addr = cfg_base + ADDR_W'(scb_off);
      ST_CB:   mem_addr = ctl_base + ADDR_W'(idx_q);
      default: mem_addr = '0;
    endcase
  end

  assign st        = st_q;
  assign idx       = idx_q;
  assign master    = master_q;
  assign role_set  = role_q;
  assign init_done = (st_q == ST_DONE);

  // R7: a pending read holds its request and address
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R2: master attention starts at the fixed boot address
  p_boot_start_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_IDLE && attn && sel_in) |=> (mem_req && mem_addr == BOOT_ADDR));

  // R3: a waiting slave issues nothing without attention
  p_slave_quiet_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_SLV_WAIT && !attn) |=> !mem_req);

  // R3: role never changes once chosen
  p_role_fixed_r3: assert property (@(posedge clk) disable iff (!srst_n)
    role_q |=> (role_q && $stable(master_q)));

  // R8: done is sticky and silent
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!srst_n)
    init_done |=> (init_done && !mem_req));
endmodule

// File: rtl/iop_field_regs.sv
module iop_field_regs
  import iop_boot_pkg::*;
(
  input  logic                        clk,
  input  logic                        srst_n,
  input  logic                        accept,
  input  seq_st_e                     st,
  input  logic [IDX_W-1:0]            idx,
  input  logic [BYTE_W-1:0]           rdata,
  output logic [BYTE_W-1:0]           bus_kind,
  output logic [1:0]                  soc_bits,
  output logic [NPTR-1:0][PTR_W-1:0]  seg,
  output logic [NPTR-1:0][PTR_W-1:0]  off
);
  logic [BYTE_W-1:0]          kind_q, kind_d;
  logic [1:0]                 soc_q, soc_d;
  logic [NPTR-1:0][PTR_W-1:0] seg_q, seg_d;
  logic [NPTR-1:0][PTR_W-1:0] off_q, off_d;
  logic [1:0]                 ph;
  logic                       ph_ok;
  logic                       lead;   // a leading non-pointer byte precedes the pointer
  logic [IDX_W-1:0]           k;

  always_comb begin
    ph_ok = 1'b1;
    case (st)
      ST_BOOT: ph = 2'd0;
      ST_SCB:  ph = 2'd1;
      ST_CB:   ph = 2'd2;
      default: begin ph = 2'd0; ph_ok = 1'b0; end
    endcase
  end

  assign lead = (ph != 2'(NPTR-1));
  assign k    = idx - IDX_W'(lead);

  // next-state process
  always_comb begin
    kind_d = kind_q;
    soc_d  = soc_q;
    seg_d  = seg_q;
    off_d  = off_q;
    if (accept && ph_ok) begin
      if (lead && idx == '0) begin
        if (ph == 2'd0) kind_d = rdata;
        else            soc_d  = rdata[1:0];
      end else begin
        case (k[1:0])
          2'd0: off_d[ph][BYTE_W-1:0]      = rdata;
          2'd1: off_d[ph][PTR_W-1:BYTE_W]  = rdata;
          2'd2: seg_d[ph][BYTE_W-1:0]      = rdata;
          default: seg_d[ph][PTR_W-1:BYTE_W] = rdata;
        endcase
      end
    end
  end

  // register process with explicit enable
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      kind_q <= '0;
      soc_q  <= '0;
      seg_q  <= '0;
      off_q  <= '0;
    end else if (accept) begin
      kind_q <= kind_d;
      soc_q  <= soc_d;
      seg_q  <= seg_d;
      off_q  <= off_d;
    end
  end

  assign bus_kind = kind_q;
  assign soc_bits = soc_q;
  assign seg      = seg_q;
  assign off      = off_q;

  // R8: fields only move when a byte is accepted
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !accept |=> ($stable(seg_q) && $stable(off_q) && $stable(soc_q)));
endmodule

// File: rtl/iop_boot_seq.sv
module iop_boot_seq
  import iop_boot_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_ADDR      = 20'hFFFF6,
  parameter logic [ADDR_W-1:0] SLAVE_CFG_BASE = 20'h00400,
  parameter int                CH_STRIDE      = 8,
  parameter int                RST_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attn,
  input  logic              sel_in,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              is_master,
  output logic              io_bus16,
  output logic              arb_mode1,
  output logic [BYTE_W-1:0] sys_bus_kind,
  output logic [ADDR_W-1:0] cfg_blk_addr,
  output logic [ADDR_W-1:0] ctl_blk_addr,
  output logic [ADDR_W-1:0] ch1_tbl_addr,
  output logic [ADDR_W-1:0] ch2_tbl_addr,
  output logic              init_done
);
  logic                        srst_n;
  seq_st_e                     st;
  logic [IDX_W-1:0]            idx;
  logic                        accept;
  logic                        master;
  logic                        role_set;
  logic [1:0]                  soc_bits;
  logic [NPTR-1:0][PTR_W-1:0]  seg;
  logic [NPTR-1:0][PTR_W-1:0]  off;
  logic [NPTR-1:0][ADDR_W-1:0] ptr_addr;
  logic [ADDR_W-1:0]           cfg_base;

  iop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  iop_seq_fsm #(.BOOT_ADDR(BOOT_ADDR)) u_fsm (
    .clk(clk), .srst_n(srst_n), .attn(attn), .sel_in(sel_in),
    .mem_rvalid(mem_rvalid), .cfg_base(cfg_base), .ctl_base(ptr_addr[1]),
    .mem_req(mem_req), .mem_addr(mem_addr), .st(st), .idx(idx),
    .accept(accept), .master(master), .role_set(role_set),
    .init_done(init_done)
  );

  iop_field_regs u_fields (
    .clk(clk), .srst_n(srst_n), .accept(accept), .st(st), .idx(idx),
    .rdata(mem_rdata), .bus_kind(sys_bus_kind), .soc_bits(soc_bits),
    .seg(seg), .off(off)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    iop_seg_adder #(
      .SEG_W(PTR_W), .OFF_W(PTR_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
    ) u_add (
      .seg(seg[g]), .off(off[g]), .addr(ptr_addr[g])
    );
  end

  assign cfg_base     = (role_set && !master) ? SLAVE_CFG_BASE : ptr_addr[0];
  assign is_master    = master;
  assign io_bus16     = soc_bits[0];
  assign arb_mode1    = soc_bits[1];
  assign cfg_blk_addr = cfg_base;
  assign ctl_blk_addr = ptr_addr[1];
  assign ch1_tbl_addr = ptr_addr[2];
  assign ch2_tbl_addr = ptr_addr[2] + ADDR_W'(CH_STRIDE);

  // R1: nothing is requested before a role exists
  p_idle_until_role_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !role_set |-> (!mem_req && !init_done));
endmodule

// File: tb/iop_boot_seq_tb_top.sv
`timescale 1ns/1ps
module iop_boot_seq_tb_top;
  localparam int MASK = 32'hFFFFF;
  localparam int SLV_BASE = 32'h00400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        attn, sel_in, mem_rvalid;
  logic [7:0]  mem_rdata;
  logic        mem_req, is_master, io_bus16, arb_mode1, init_done;
  logic [19:0] mem_addr, cfg_blk_addr, ctl_blk_addr, ch1_tbl_addr, ch2_tbl_addr;
  logic [7:0]  sys_bus_kind;

  iop_boot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .attn(attn), .sel_in(sel_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .is_master(is_master), .io_bus16(io_bus16),
    .arb_mode1(arb_mode1), .sys_bus_kind(sys_bus_kind),
    .cfg_blk_addr(cfg_blk_addr), .ctl_blk_addr(ctl_blk_addr),
    .ch1_tbl_addr(ch1_tbl_addr), .ch2_tbl_addr(ch2_tbl_addr),
    .init_done(init_done)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  logic [7:0] mem [int];
  int    q_addr[$];
  string q_tag[$];

  bit m_req, m_done, lat_rand;
  int m_role, m_cnt, wait_cnt, lat;
  int e_master, e_kind, e_soc, e_cfg, e_ctl, e_ch1;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  function automatic logic [7:0] rd(input int a);
    if (mem.exists(a & MASK)) return mem[a & MASK];
    return 8'h00;
  endfunction

  task automatic put16(input int a, input int v);
    mem[a & MASK]       = v[7:0];
    mem[(a + 1) & MASK] = v[15:8];
  endtask

  function automatic int ptr_at(input int a);
    int o, s;
    o = {rd(a + 1), rd(a)};
    s = {rd(a + 3), rd(a + 2)};
    return ((s << 4) + o) & MASK;
  endfunction

  task automatic push_tail(input int cfg);
    q_addr.push_back(cfg & MASK); q_tag.push_back("R4");
    for (int i = 2; i <= 5; i++) begin
      q_addr.push_back((cfg + i) & MASK); q_tag.push_back("R5");
    end
    e_soc = rd(cfg);
    e_ctl = ptr_at(cfg + 2);
    for (int i = 0; i < 4; i++) begin
      q_addr.push_back((e_ctl + i) & MASK); q_tag.push_back("R6");
    end
    e_ch1 = ptr_at(e_ctl);
  endtask

  task automatic build_master();
    q_addr.delete(); q_tag.delete();
    for (int i = 0; i < 5; i++) begin
      q_addr.push_back(32'hFFFF6 + i); q_tag.push_back("R2");
    end
    e_master = 1;
    e_kind = rd(32'hFFFF6);
    e_cfg = ptr_at(32'hFFFF7);
    push_tail(e_cfg);
  endtask

  task automatic build_slave();
    q_addr.delete(); q_tag.delete();
    e_master = 0;
    e_kind = 0;
    e_cfg = SLV_BASE;
    push_tail(e_cfg);
  endtask

  // one cycle: compare at falling edge, drive, advance model, wait next falling edge
  task automatic cyc(input logic a, input logic s);
    bit rv;
    chk(mem_req === m_req, m_role == 1 ? "R3" : (m_done ? "R8" : "R7"), mem_req, m_req);
    if (m_req) chk(mem_addr === q_addr[0][19:0], q_tag[0], mem_addr, q_addr[0]);
    chk(init_done === m_done, "R8", init_done, m_done);
    rv = m_req && (wait_cnt >= lat);
    attn = a;
    sel_in = s;
    mem_rvalid = rv;
    mem_rdata = rv ? rd(q_addr[0]) : 8'hA5;
    if (m_cnt >= 2) begin
      if (m_req && rv) begin
        void'(q_addr.pop_front()); void'(q_tag.pop_front());
        wait_cnt = 0;
        if (lat_rand) lat = $urandom_range(0, 3);
        if (q_addr.size() == 0) begin m_req = 0; m_done = 1; end
      end else if (m_req) begin
        wait_cnt++;
      end else if (!m_done && a) begin
        if (m_role == 0) begin
          if (s) begin build_master(); m_req = 1; m_role = 2; end
          else m_role = 1;
        end else if (m_role == 1) begin
          build_slave(); m_req = 1; m_role = 2;
        end
      end
    end
    m_cnt++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; attn = 0; sel_in = 0; mem_rvalid = 0; mem_rdata = 0;
    repeat (5) @(negedge clk);
    chk(mem_req === 1'b0, "R1", mem_req, 0);
    chk(init_done === 1'b0, "R1", init_done, 0);
    chk(is_master === 1'b0, "R1", is_master, 0);
    chk(ch1_tbl_addr === 20'h0, "R1", ch1_tbl_addr, 0);
    chk(cfg_blk_addr === 20'h0 && ctl_blk_addr === 20'h0, "R1", cfg_blk_addr, 0);
    rst_n = 1'b1;
    m_req = 0; m_done = 0; m_role = 0; m_cnt = 0; wait_cnt = 0;
  endtask

  task automatic run_seq(input bit noise);
    int n = 0;
    while (!m_done && n < 400) begin
      cyc(noise ? ($urandom_range(0, 3) == 0) : 1'b0, 1'($urandom_range(0, 1)));
      n++;
    end
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'(i & 1));   // R8: late attention ignored
  endtask

  task automatic final_check();
    chk(is_master === 1'(e_master), "R3", is_master, e_master);
    chk(sys_bus_kind === 8'(e_kind), "R2", sys_bus_kind, e_kind);
    chk(cfg_blk_addr === 20'(e_cfg), "R4", cfg_blk_addr, e_cfg);
    chk(io_bus16 === 1'(e_soc & 1), "R5", io_bus16, e_soc & 1);
    chk(arb_mode1 === 1'((e_soc >> 1) & 1), "R5", arb_mode1, (e_soc >> 1) & 1);
    chk(ctl_blk_addr === 20'(e_ctl), "R5", ctl_blk_addr, e_ctl);
    chk(ch1_tbl_addr === 20'(e_ch1), "R6", ch1_tbl_addr, e_ch1);
    chk(ch2_tbl_addr === 20'((e_ch1 + 8) & MASK), "R6", ch2_tbl_addr, (e_ch1 + 8) & MASK);
  endtask

  initial begin
    @(negedge clk);
    // Scenario 1: master, zero latency, attention during reset release (R9)
    mem.delete();
    mem[32'hFFFF6] = 8'h01;
    put16(32'hFFFF7, 32'h0010); put16(32'hFFFF9, 32'h1234);   // cfg = 0x12350
    mem[32'h12350] = 8'h01; mem[32'h12351] = 8'hEE;
    put16(32'h12352, 32'h0004); put16(32'h12354, 32'h2000);   // ctl = 0x20004
    put16(32'h20004, 32'h0100); put16(32'h20006, 32'h3000);   // ch1 = 0x30100
    lat_rand = 0; lat = 0;
    do_reset();
    cyc(1'b1, 1'b1);            // R9: dead edge
    cyc(1'b1, 1'b1);            // R9: dead edge
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b1);
    run_seq(1'b0);
    final_check();

    // Scenario 2: master, segment wraps, random latency, noisy attention
    mem.delete();
    mem[32'hFFFF6] = 8'h00;
    put16(32'hFFFF7, 32'h0030); put16(32'hFFFF9, 32'hFFFF);   // cfg wraps to 0x00020
    mem[32'h00020] = 8'h02; mem[32'h00021] = 8'h5A;
    put16(32'h00022, 32'hFFF8); put16(32'h00024, 32'h0001);   // ctl = 0x10008
    put16(32'h10008, 32'h00FC); put16(32'h1000A, 32'hFFFF);   // ch1 wraps to 0x000EC
    lat_rand = 1; lat = 2;
    do_reset();
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b1);
    run_seq(1'b1);
    final_check();

    // Scenario 3: slave, later attention with select high
    mem.delete();
    mem[SLV_BASE] = 8'h03; mem[SLV_BASE + 1] = 8'h77;
    put16(SLV_BASE + 2, 32'h0000); put16(SLV_BASE + 4, 32'h0050);  // ctl = 0x00500
    put16(32'h00500, 32'hFFFC); put16(32'h00502, 32'hF000);        // ch1 = 0xFFFFC
    mem[32'hFFFF6] = 8'h99;
    lat_rand = 1; lat = 1;
    do_reset();
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);            // R3: becomes slave
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1);   // R3: stays silent
    cyc(1'b1, 1'b1);
    run_seq(1'b1);
    final_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule